// File: doc/BRIEF.md
# Synchronizing Word Access Unit

This block sits between a processor's load/store port and a small word-addressed store. Every word holds a data value and one extra synchronization bit that is either full (1) or empty (0). Each request carries an 8-bit access code. Eight of the code values select a synchronizing flavor, and the flavor fixes three things: whether a load of an empty word (or a store to a full word) traps, whether the access also empties the bit (load) or fills it (store), and whether a cache miss traps the core or stalls it. All other code values give a plain access that ignores the bit.

A request whose flavor never traps on the bit instead copies the word's bit into a condition flag, which branch-on-full and branch-on-empty logic can test. The cache-miss indication arrives from outside with the request. A stalled request holds the core until a miss-resolved input is raised, and then completes exactly as it would have done without the miss.

Top module: `fe_mem_access`

## Requirements
- R1: After reset every word's bit is empty, cond_full is 0, and hold, rsp_done, trap_sync and trap_miss are low.
- R2: A request is accepted on a rising edge where req_valid is high and hold is low. Its outcome pulses for one cycle after that edge. Code 8'h40+k (k = 0..7) selects flavor k+1, and req_store chooses load or store. Every other code value is a plain access.
- R3: Flavors 1, 2, 7 and 8 raise trap_sync when a load finds the word empty or a store finds it full. A trapped access changes neither the data nor the bit, and rsp_done stays low.
- R4: After a successful access, flavors 2, 4, 6 and 8 leave the bit empty for a load and full for a store. Flavors 1, 3, 5 and 7 leave the bit unchanged.
- R5: A successful store writes req_wdata to the word. A successful load raises rsp_done and presents the word on rsp_rdata in the same cycle.
- R6: Flavors 3 to 6 never raise trap_sync. They load cond_full with the word's bit as it was before any update. Trapping flavors and plain accesses leave cond_full unchanged.
- R7: A request with miss_in high and flavor 1 to 4 raises trap_miss. It performs no bit check and changes nothing.
- R8: A request with miss_in high and flavor 5 to 8, or a plain code, raises hold from the next cycle. Hold stays high until the edge on which miss_done is high. On that edge the access is performed, and in the following cycle its result appears and hold is low.
- R9: A plain access never raises trap_sync, never changes the bit, and completes loads and stores like R5.
- R10: In any cycle at most one of rsp_done, trap_sync and trap_miss is high. A request presented while hold is high is ignored and leaves no trace on data or bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 for store, 0 for load |
| req_code | input | 8 | Access code selecting flavor or plain access |
| req_addr | input | AW (4) | Word address |
| req_wdata | input | DW (32) | Store data |
| miss_in | input | 1 | Cache miss for the presented request |
| miss_done | input | 1 | Miss of the stalled request is resolved |
| hold | output | 1 | Core is stalled on a miss |
| rsp_done | output | 1 | Access completed |
| rsp_rdata | output | DW (32) | Load data |
| trap_sync | output | 1 | Synchronization trap |
| trap_miss | output | 1 | Cache-miss trap |
| cond_full | output | 1 | Condition flag holding the last sampled bit |

## Verification
The checker assumes that miss_in has meaning only alongside an accepted request. It also assumes that miss_done is raised only while hold is high, and for no more than one cycle at a time. The bench drives miss_done only during a stall and drops it right after that edge. It presents a request during a stall only to show that the request is ignored. Memory data is written by a store before it is ever read back, because the data words carry no reset value.

// File: rtl/fe_sync_pkg.sv
package fe_sync_pkg;
  typedef struct packed {
    logic plain;
    logic trap_sync_en;
    logic upd_bit;
    logic trap_on_miss;
  } acc_ctl_t;

  typedef enum logic {ST_IDLE, ST_WAIT} acc_st_t;
endpackage

// File: rtl/fe_flavor_dec.sv
module fe_flavor_dec
  import fe_sync_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h40
) (
  input  logic [7:0] code,
  output acc_ctl_t   ctl
);
  logic       is_flav;
  logic [2:0] k;

  always_comb begin
    is_flav          = (code[7:3] == BASE[7:3]);
    k                = code[2:0];
    ctl.plain        = !is_flav;
    // flavors 1,2,7,8 (k = 0,1,6,7) test the bit
    ctl.trap_sync_en = is_flav && (k[2] ~^ k[1]);
    ctl.upd_bit      = is_flav && k[0];
    ctl.trap_on_miss = is_flav && !k[2];
  end
endmodule

// File: rtl/fe_word_store.sv
module fe_word_store #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          bit_we,
  input  logic          bit_val,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_bit
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           sync_q[g] <= 1'b0;
      else if (bit_we && (wr_addr == g[AW-1:0])) sync_q[g] <= bit_val;
    end
  end

  assign rd_data = data_q[rd_addr];
  assign rd_bit  = sync_q[rd_addr];
endmodule

// File: rtl/fe_mem_access.sv
module fe_mem_access
  import fe_sync_pkg::*;
#(
  parameter int         DW   = 32,
  parameter int         AW   = 4,
  parameter logic [7:0] BASE = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [7:0]    req_code,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          miss_in,
  input  logic          miss_done,
  output logic          hold,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          trap_sync,
  output logic          trap_miss,
  output logic          cond_full
);
  acc_ctl_t      ctl_req, p_ctl, x_ctl;
  acc_st_t       st_q, st_d;
  logic          p_store, x_store;
  logic [AW-1:0] p_addr, x_addr;
  logic [DW-1:0] p_wdata, x_wdata;
  logic          accept, go_wait, go_tmiss, from_wait, exec, sync_fail;
  logic [DW-1:0] rd_data;
  logic          rd_bit;
  logic          wr_en, bit_we, cond_en, rdata_en;
  logic          done_d, tsync_d, tmiss_d, cond_d;
  logic          done_q, tsync_q, tmiss_q, cond_q;
  logic [DW-1:0] rdata_q;

  fe_flavor_dec #(.BASE(BASE)) u_dec (.code(req_code), .ctl(ctl_req));

  fe_word_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(x_addr), .wr_data(x_wdata),
    .bit_we(bit_we), .bit_val(x_store),
    .rd_addr(x_addr), .rd_data(rd_data), .rd_bit(rd_bit)
  );

  always_comb begin
    accept    = req_valid && (st_q == ST_IDLE);
    go_tmiss  = accept && miss_in && ctl_req.trap_on_miss;
    go_wait   = accept && miss_in && !ctl_req.trap_on_miss;
    from_wait = (st_q == ST_WAIT) && miss_done;
    exec      = (accept && !miss_in) || from_wait;
    x_store   = from_wait ? p_store : req_store;
    x_ctl     = from_wait ? p_ctl   : ctl_req;
    x_addr    = from_wait ? p_addr  : req_addr;
    x_wdata   = from_wait ? p_wdata : req_wdata;
    sync_fail = x_ctl.trap_sync_en && (x_store ? rd_bit : !rd_bit);
    wr_en     = exec && x_store && !sync_fail;
    bit_we    = exec && x_ctl.upd_bit && !sync_fail;
    cond_en   = exec && !x_ctl.plain && !x_ctl.trap_sync_en;
    rdata_en  = exec && !x_store && !sync_fail;
    done_d    = exec && !sync_fail;
    tsync_d   = exec && sync_fail;
    tmiss_d   = go_tmiss;
    cond_d    = cond_en ? rd_bit : cond_q;
    st_d      = st_q;
    if (go_wait)   st_d = ST_WAIT;
    if (from_wait) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      tsync_q <= 1'b0;
      tmiss_q <= 1'b0;
      cond_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      tsync_q <= tsync_d;
      tmiss_q <= tmiss_d;
      cond_q  <= cond_d;
      if (rdata_en) rdata_q <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (go_wait) begin
      p_store <= req_store;
      p_ctl   <= ctl_req;
      p_addr  <= req_addr;
      p_wdata <= req_wdata;
    end
  end

  assign hold      = (st_q == ST_WAIT);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign trap_sync = tsync_q;
  assign trap_miss = tmiss_q;
  assign cond_full = cond_q;
endmodule

// File: rtl/fe_mem_access_chk.sv
module fe_mem_access_chk #(
  parameter logic [7:0] BASE = 8'h40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [7:0] req_code,
  input logic       miss_in,
  input logic       miss_done,
  input logic       hold,
  input logic       rsp_done,
  input logic       trap_sync,
  input logic       trap_miss,
  input logic       cond_full
);
  logic is_flav, miss_traps;
  assign is_flav    = (req_code[7:3] == BASE[7:3]);
  assign miss_traps = is_flav && !req_code[2];

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_done, trap_sync, trap_miss})); // R10
  AST_IGNORE_WHILE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !miss_done |=> !rsp_done && !trap_sync && !trap_miss); // R10
  AST_MISS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hold && miss_in && miss_traps |=> trap_miss && !hold); // R7
  AST_MISS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hold && miss_in && !miss_traps |=> hold && !rsp_done); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    hold && miss_done |=> !hold && (rsp_done ^ trap_sync)); // R8
  AST_COND_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_sync |-> $stable(cond_full)); // R6
  AST_PLAIN_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hold && !miss_in && !is_flav |=> rsp_done); // R9
endmodule

bind fe_mem_access fe_mem_access_chk #(.BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
  .miss_in(miss_in), .miss_done(miss_done), .hold(hold), .rsp_done(rsp_done),
  .trap_sync(trap_sync), .trap_miss(trap_miss), .cond_full(cond_full)
);

// File: tb/test_fe_mem_access.sv
module test_fe_mem_access;
  logic        clk, rst_n;
  logic        req_valid, req_store, miss_in, miss_done;
  logic [7:0]  req_code;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic        hold, rsp_done, trap_sync, trap_miss, cond_full;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;

  fe_mem_access i_fe_mem_access (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_code(req_code), .req_addr(req_addr), .req_wdata(req_wdata),
    .miss_in(miss_in), .miss_done(miss_done), .hold(hold), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .trap_sync(trap_sync), .trap_miss(trap_miss),
    .cond_full(cond_full)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] fl(input int n);
    return 8'h40 + 8'(n - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic st, input logic [7:0] code, input logic [3:0] a,
                        input logic [31:0] wd, input logic miss);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_code = code;
    req_addr = a; req_wdata = wd; miss_in = miss;
    @(negedge clk);
    req_valid = 1'b0; miss_in = 1'b0;
  endtask

  // flavor 3: no bit trap, no update; exposes bit via cond_full
  task automatic probe(input logic [3:0] a);
    access(1'b0, fl(3), a, 32'h0, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 hold", {31'b0, hold}, 0);
    check("R1 outcomes", {29'b0, rsp_done, trap_sync, trap_miss}, 0);
    check("R1 cond", {31'b0, cond_full}, 0);
    probe(4'd15);
    check("R1 bit empty", {31'b0, cond_full}, 0);
    check("R6 done", {31'b0, rsp_done}, 1);
  endtask

  task automatic t_sync_trap;
    access(1'b0, fl(1), 4'd0, 0, 1'b0);
    check("R3 load empty traps", {30'b0, trap_sync, rsp_done}, 32'h2);
    access(1'b1, fl(2), 4'd0, 32'hA5A5_0001, 1'b0);
    check("R5 store done", {31'b0, rsp_done}, 1);
    probe(4'd0);
    check("R4 store sets full", {31'b0, cond_full}, 1);
    check("R5 data", rsp_rdata, 32'hA5A5_0001);
    access(1'b1, fl(2), 4'd0, 32'hDEAD_0000, 1'b0);
    check("R3 store full traps", {30'b0, trap_sync, rsp_done}, 32'h2);
    probe(4'd0);
    check("R3 data kept", rsp_rdata, 32'hA5A5_0001);
  endtask

  task automatic t_reset_bit;
    access(1'b0, fl(2), 4'd0, 0, 1'b0);
    check("R5 load data", rsp_rdata, 32'hA5A5_0001);
    check("R6 trapping flavor keeps cond", {31'b0, cond_full}, 1);
    probe(4'd0);
    check("R4 load empties", {31'b0, cond_full}, 0);
    access(1'b0, fl(8), 4'd0, 0, 1'b0);
    check("R3 flavor8 traps on empty", {31'b0, trap_sync}, 1);
  endtask

  task automatic t_no_trap_flavors;
    access(1'b1, fl(3), 4'd1, 32'h0000_BEEF, 1'b0);
    check("R6 store no trap", {30'b0, rsp_done, trap_sync}, 32'h2);
    probe(4'd1);
    check("R4 odd flavor leaves bit", {31'b0, cond_full}, 0);
    access(1'b1, fl(4), 4'd1, 32'h1234_5678, 1'b0);
    check("R6 cond is bit before update", {31'b0, cond_full}, 0);
    access(1'b0, fl(5), 4'd1, 0, 1'b0);
    check("R6 cond full", {31'b0, cond_full}, 1);
    check("R5 data flavor5", rsp_rdata, 32'h1234_5678);
    access(1'b1, fl(6), 4'd1, 32'h1234_5678, 1'b0);
    check("R6 store on full no trap", {30'b0, rsp_done, trap_sync}, 32'h2);
  endtask

  task automatic t_plain;
    access(1'b1, 8'h08, 4'd2, 32'h0F0F_0F0F, 1'b0);
    check("R9 plain store done", {31'b0, rsp_done}, 1);
    access(1'b0, 8'h08, 4'd2, 0, 1'b0);
    check("R9 plain load data", rsp_rdata, 32'h0F0F_0F0F);
    check("R9 cond unchanged", {31'b0, cond_full}, 1);
    access(1'b0, 8'hFF, 4'd0, 0, 1'b0);
    check("R2 other code plain, no trap", {30'b0, rsp_done, trap_sync}, 32'h2);
    probe(4'd2);
    check("R9 bit untouched", {31'b0, cond_full}, 0);
  endtask

  task automatic t_miss_trap;
    access(1'b0, fl(1), 4'd1, 0, 1'b1);
    check("R7 miss trap", {29'b0, trap_miss, trap_sync, rsp_done}, 32'h4);
    check("R7 no hold", {31'b0, hold}, 0);
    access(1'b1, fl(4), 4'd1, 32'hBAD0_BAD0, 1'b1);
    check("R7 store miss trap", {31'b0, trap_miss}, 1);
    probe(4'd1);
    check("R7 bit kept", {31'b0, cond_full}, 1);
    check("R7 data kept", rsp_rdata, 32'h1234_5678);
  endtask

  task automatic t_miss_wait;
    access(1'b0, fl(8), 4'd1, 0, 1'b1);
    check("R8 hold raised", {31'b0, hold}, 1);
    check("R8 no outcome yet", {29'b0, rsp_done, trap_sync, trap_miss}, 0);
    access(1'b1, 8'h08, 4'd1, 32'hFFFF_0000, 1'b0);
    check("R10 still holding", {31'b0, hold}, 1);
    check("R10 ignored request", {31'b0, rsp_done}, 0);
    @(negedge clk); miss_done = 1'b1;
    @(negedge clk); miss_done = 1'b0;
    check("R8 hold released", {31'b0, hold}, 0);
    check("R8 done after resolve", {30'b0, rsp_done, trap_sync}, 32'h2);
    check("R8 load data", rsp_rdata, 32'h1234_5678);
    probe(4'd1);
    check("R8 flavor8 emptied bit", {31'b0, cond_full}, 0);
    check("R10 ignored store left data", rsp_rdata, 32'h1234_5678);
    access(1'b0, fl(7), 4'd1, 0, 1'b1);
    check("R8 hold flavor7", {31'b0, hold}, 1);
    @(negedge clk); miss_done = 1'b1;
    @(negedge clk); miss_done = 1'b0;
    check("R3 sync trap after stall", {30'b0, trap_sync, rsp_done}, 32'h2);
    check("R8 released", {31'b0, hold}, 0);
    access(1'b1, 8'h0A, 4'd3, 32'h0000_0033, 1'b1);
    check("R8 plain waits", {31'b0, hold}, 1);
    @(negedge clk); miss_done = 1'b1;
    @(negedge clk); miss_done = 1'b0;
    check("R8 plain done", {31'b0, rsp_done}, 1);
    access(1'b0, 8'h0A, 4'd3, 0, 1'b0);
    check("R8 plain stored", rsp_rdata, 32'h0000_0033);
  endtask

  initial begin
    req_valid = 0; req_store = 0; req_code = 0; req_addr = 0;
    req_wdata = 0; miss_in = 0; miss_done = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_sync_trap;
    t_reset_bit;
    t_no_trap_flavors;
    t_plain;
    t_miss_trap;
    t_miss_wait;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule